// File: doc/BRIEF.md
# Register-Pair Byte Stack Engine

This block runs a stack that grows toward lower addresses in a byte-wide synchronous memory, using a 16-bit stack pointer. It takes three commands: set the stack pointer, save a 16-bit register pair, and restore a 16-bit register pair. Each pair moves as two bytes in two consecutive memory cycles. The high byte always sits at the higher address.

A save lowers the pointer before each byte is written. A restore reads the byte under the pointer and raises the pointer after each read. After a save, the pointer therefore addresses the low byte just written, which is the top of the stack. Restores never write, so popped bytes stay in memory until a later save writes over them. The memory sits outside the block. It is reached through an address, write data, write strobe and read data port, and its read data arrives one clock after the address.

Top module: `pair_stack_engine`

## Requirements
- R1: Reset state: after reset, `sp` is `SP_RESET` (0x0000 by default), and `busy`, `done`, `mem_we` and `pop_data` are all 0.
- R2: Load: `cmd_op`=1 with `cmd_valid` while idle sets `sp` to `cmd_data` at the next edge. `done` is high for the following cycle and `busy` stays low.
- R3: Save:
  - `cmd_op`=2 writes `cmd_data[15:8]` at `sp`-1 in the cycle after acceptance.
  - It then writes `cmd_data[7:0]` at `sp`-2 in the next cycle.
  - `sp` ends at `sp`-2, so an accumulator/flags pair puts the accumulator at the higher address.
- R4: Restore:
  - `cmd_op`=3 reads the byte at `sp` into `pop_data[7:0]` and the byte at `sp`+1 into `pop_data[15:8]`.
  - `sp` ends at `sp`+2.
  - `pop_data` holds its value until the next restore completes.
- R5: Nested saves come back in reverse order (last saved, first restored).
- R6: A restore never asserts `mem_we`. Reloading the pointer and restoring again returns the same pair.
- R7: Pointer arithmetic wraps modulo 2^16 for both saves and restores.
- R8: `busy` is high for exactly 2 cycles per save, 3 per restore and 0 per load. Any command presented while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse. It rises 1, 3 or 4 clock edges after a load, save or restore is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 1 load, 2 save pair, 3 restore pair, 0 none |
| cmd_data | input | 16 | Pointer value or pair to save |
| busy | output | 1 | Save or restore in progress |
| done | output | 1 | One-cycle completion pulse |
| pop_data | output | 16 | Last restored pair |
| sp | output | 16 | Current stack pointer |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read byte, one cycle after address |

## Verification
The scoreboard predicts every memory write and every completion. A pointer that is off by one therefore shows up as a wrong address on the very first write strobe of the next save. On a restore, the same fault shows up as a wrong `sp` or a swapped or shifted `pop_data` at the `done` pulse. A stuck or skipped sequencer state shows up within a few cycles: the busy count comes out wrong, `done` goes missing or doubles, or a write appears during a restore with no expected write queued. Commands injected while `busy` is high would show up in the next `sp` comparison.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_PUSH = 2'd2,
    OP_POP  = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_A,
    ST_POP_B,
    ST_POP_C
  } stk_state_e;
endpackage

// File: rtl/stk_sp_reg.sv
module stk_sp_reg #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] ONE = AW'(1);

  always_ff @(posedge clk) begin
    if (rst)      sp <= SP_RESET;
    else if (ld)  sp <= ld_val;
    else if (dec) sp <= sp - ONE;
    else if (inc) sp <= sp + ONE;
  end
endmodule

// File: rtl/stk_pop_asm.sv
module stk_pop_asm #(
  parameter int BW    = 8,
  parameter int LANES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    cap_en,
  input  logic [BW-1:0]       byte_in,
  output logic [LANES*BW-1:0] pair
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)            pair[g*BW +: BW] <= '0;
      else if (cap_en[g]) pair[g*BW +: BW] <= byte_in;
    end
  end
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [2*BW-1:0] cmd_data,
  input  logic [AW-1:0]   sp,
  output logic            sp_ld,
  output logic            sp_dec,
  output logic            sp_inc,
  output logic [1:0]      cap_en,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            busy,
  output logic            done
);
  localparam logic [AW-1:0] ONE = AW'(1);

  stk_state_e      state;
  logic [BW-1:0]   lo_hold;
  logic            idle_cmd;
  stk_op_e         op;
  logic [AW-1:0]   sp_m1, sp_p1;

  assign op       = stk_op_e'(cmd_op);
  assign idle_cmd = (state == ST_IDLE) && cmd_valid;
  assign sp_m1    = sp - ONE;
  assign sp_p1    = sp + ONE;

  always_comb begin
    sp_ld  = idle_cmd && (op == OP_LOAD);
    sp_dec = (idle_cmd && (op == OP_PUSH)) || (state == ST_PUSH_HI);
    sp_inc = (state == ST_POP_A) || (state == ST_POP_B);
    cap_en = {state == ST_POP_C, state == ST_POP_B};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      lo_hold   <= '0;
    end else begin
      done   <= 1'b0;
      mem_we <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            case (op)
              OP_LOAD: done <= 1'b1;
              OP_PUSH: begin
                state     <= ST_PUSH_HI;
                mem_addr  <= sp_m1;
                mem_wdata <= cmd_data[2*BW-1:BW];
                lo_hold   <= cmd_data[BW-1:0];
                mem_we    <= 1'b1;
                busy      <= 1'b1;
              end
              OP_POP: begin
                state    <= ST_POP_A;
                mem_addr <= sp;
                busy     <= 1'b1;
              end
              default: ;
            endcase
          end
        end
        ST_PUSH_HI: begin
          state     <= ST_PUSH_LO;
          mem_addr  <= sp_m1;
          mem_wdata <= lo_hold;
          mem_we    <= 1'b1;
        end
        ST_PUSH_LO: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        ST_POP_A: begin
          state    <= ST_POP_B;
          mem_addr <= sp_p1;
        end
        ST_POP_B: state <= ST_POP_C;
        ST_POP_C: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: restore states never drive a write strobe
  p_pop_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_POP_A || state == ST_POP_B || state == ST_POP_C) |-> !mem_we);

  // R8: a busy sequencer is never in the idle state
  p_busy_not_idle_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (state != ST_IDLE));
endmodule

// File: rtl/pair_stack_engine.sv
module pair_stack_engine
  import stk_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [2*BW-1:0] cmd_data,
  output logic            busy,
  output logic            done,
  output logic [2*BW-1:0] pop_data,
  output logic [AW-1:0]   sp,
  output logic [AW-1:0]   mem_addr,
  output logic [BW-1:0]   mem_wdata,
  output logic            mem_we,
  input  logic [BW-1:0]   mem_rdata
);
  localparam int PW = 2 * BW;

  logic       sp_ld, sp_dec, sp_inc;
  logic [1:0] cap_en;

  stk_sp_reg #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst(rst), .ld(sp_ld), .ld_val(cmd_data[AW-1:0]),
    .dec(sp_dec), .inc(sp_inc), .sp(sp)
  );

  stk_seq #(.AW(AW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .sp(sp), .sp_ld(sp_ld), .sp_dec(sp_dec),
    .sp_inc(sp_inc), .cap_en(cap_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .busy(busy), .done(done)
  );

  stk_pop_asm #(.BW(BW), .LANES(PW / BW)) u_asm (
    .clk(clk), .rst(rst), .cap_en(cap_en), .byte_in(mem_rdata),
    .pair(pop_data)
  );

  // R2: load lands in the pointer and completes next cycle
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && !busy) |=>
      (sp == $past(cmd_data[AW-1:0]) && done));

  // R3: each write goes to the freshly lowered pointer
  p_push_addr_r3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == sp));

  // R7: second byte of a save sits one below the first, modulo 2^16
  p_push_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));

  // R8: no memory write outside a busy window
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_we);

  // R9: completion is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: tb/pair_stack_engine_tb.sv
`timescale 1ns/1ps
module pair_stack_engine_tb;
  localparam int MAW = 10;
  localparam int MD  = 1 << MAW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_data = '0;
  logic        busy, done, mem_we;
  logic [15:0] pop_data, sp, mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  pair_stack_engine u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .busy(busy), .done(done), .pop_data(pop_data),
    .sp(sp), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  // byte memory with one-cycle read latency
  logic [7:0] ram [0:MD-1];
  logic [7:0] bmem [0:MD-1];
  initial begin
    for (int i = 0; i < MD; i++) begin
      ram[i]  = 8'h00;
      bmem[i] = 8'h00;
    end
    mem_rdata = 8'h00;
  end
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[MAW-1:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[MAW-1:0]];
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard queues: {addr, byte} writes and {sp, is_pop, pair} completions
  logic [23:0] exp_wr[$];
  logic [32:0] exp_done[$];
  logic [15:0] sp_m = 16'h0000;

  always @(negedge clk) begin
    if (!rst) begin
      if (mem_we) begin
        if (exp_wr.size() == 0)
          chk(1'b0, "R6 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
        else begin
          logic [23:0] e;
          e = exp_wr.pop_front();
          chk({mem_addr, mem_wdata} == e, "R3 write addr/byte",
              {8'h0, mem_addr, mem_wdata}, {8'h0, e});
        end
      end
      if (done) begin
        if (exp_done.size() == 0)
          chk(1'b0, "R9 unexpected done", 32'h1, 32'h0);
        else begin
          logic [32:0] d;
          d = exp_done.pop_front();
          chk(sp == d[32:17], "R7 sp after command", {16'h0, sp}, {16'h0, d[32:17]});
          if (d[16])
            chk(pop_data == d[15:0], "R4 restored pair", {16'h0, pop_data},
                {16'h0, d[15:0]});
        end
      end
    end
  end

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] d,
                         input bit interfere);
    logic [15:0] a1, a2;
    int cyc;
    int n;
    string tag;
    cyc = 0;
    case (op)
      2'd1: begin
        sp_m = d;
        exp_done.push_back({sp_m, 1'b0, 16'h0});
        tag = "R2 load";
      end
      2'd2: begin
        a1 = sp_m - 16'd1;
        a2 = sp_m - 16'd2;
        exp_wr.push_back({a1, d[15:8]});
        exp_wr.push_back({a2, d[7:0]});
        bmem[a1[MAW-1:0]] = d[15:8];
        bmem[a2[MAW-1:0]] = d[7:0];
        sp_m = a2;
        exp_done.push_back({sp_m, 1'b0, 16'h0});
        cyc = 2;
        tag = "R8 save busy";
      end
      default: begin
        a1 = sp_m + 16'd1;
        exp_done.push_back({sp_m + 16'd2, 1'b1, bmem[a1[MAW-1:0]], bmem[sp_m[MAW-1:0]]});
        sp_m = sp_m + 16'd2;
        cyc = 3;
        tag = "R8 restore busy";
      end
    endcase
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_data  = d;
    @(negedge clk);
    if (interfere) begin
      cmd_op   = (op == 2'd2) ? 2'd1 : 2'd2;
      cmd_data = 16'h1234;
    end else cmd_valid = 1'b0;
    n = 0;
    while (busy && n < 10) begin
      n++;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    cmd_valid = 1'b0;
    chk(n == cyc, tag, n, cyc);
    chk(done == 1'b1, "R9 done at completion", {31'h0, done}, 32'h1);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", {31'h0, done}, 32'h0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(sp == 16'h0 && !busy && !done && !mem_we && pop_data == 16'h0,
        "R1 reset state", {sp, 13'h0, busy, done, mem_we}, 32'h0);

    run_cmd(2'd1, 16'h0200, 1'b0);          // R2
    run_cmd(2'd2, 16'hA55A, 1'b0);          // R3
    run_cmd(2'd2, 16'h1280, 1'b0);          // R3 accumulator 12, flags 80
    run_cmd(2'd3, 16'h0, 1'b0);             // R5 last saved first
    chk(pop_data == 16'h1280, "R5 LIFO first", {16'h0, pop_data}, 32'h1280);
    run_cmd(2'd3, 16'h0, 1'b0);
    chk(pop_data == 16'hA55A, "R5 LIFO second", {16'h0, pop_data}, 32'hA55A);

    // R6: reload below and restore the same bytes again
    run_cmd(2'd1, 16'h01FC, 1'b0);
    run_cmd(2'd3, 16'h0, 1'b0);
    chk(pop_data == 16'h1280, "R6 memory kept", {16'h0, pop_data}, 32'h1280);
    run_cmd(2'd3, 16'h0, 1'b0);
    chk(pop_data == 16'hA55A, "R6 memory kept 2", {16'h0, pop_data}, 32'hA55A);

    // R7: wrap on save and restore
    run_cmd(2'd1, 16'h0001, 1'b0);
    run_cmd(2'd2, 16'hBEEF, 1'b0);
    chk(sp == 16'hFFFF, "R7 wrap save", {16'h0, sp}, 32'hFFFF);
    run_cmd(2'd3, 16'h0, 1'b0);
    chk(pop_data == 16'hBEEF && sp == 16'h0001, "R7 wrap restore",
        {pop_data, sp}, 32'hBEEF0001);

    // R8: commands during busy are ignored
    run_cmd(2'd1, 16'h0300, 1'b0);
    run_cmd(2'd2, 16'hC0DE, 1'b1);
    chk(sp == 16'h02FE, "R8 ignore during save", {16'h0, sp}, 32'h02FE);
    run_cmd(2'd3, 16'h0, 1'b1);
    chk(sp == 16'h0300 && pop_data == 16'hC0DE, "R8 ignore during restore",
        {pop_data, sp}, 32'hC0DE0300);

    // R5: deeper nesting with several patterns
    for (int k = 0; k < 4; k++) run_cmd(2'd2, 16'h1111 * (k + 1), 1'b0);
    for (int k = 3; k >= 0; k--) begin
      run_cmd(2'd3, 16'h0, 1'b0);
      chk(pop_data == 16'h1111 * (k + 1), "R5 nested order",
          {16'h0, pop_data}, 32'h1111 * (k + 1));
    end

    repeat (3) @(negedge clk);
    chk(exp_wr.size() == 0 && exp_done.size() == 0, "R9 all events seen",
        exp_wr.size() + exp_done.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule